// File: doc/BRIEF.md
# System-Bus to Peripheral-Bus Bridge

This block sits as a single slave on a pipelined AHB-style system bus and turns each selected transfer into one access on an APB-style peripheral bus. It samples the address, direction and slave select during the system-bus address phase. It then stalls the system bus by pulling its ready output low, and runs a fixed three-edge peripheral access of the form setup, enable, done. For reads, it returns the captured peripheral data in the cycle where ready rises again.

A parameterised number of peripherals share the bus. Each peripheral owns a fixed-size address window, chosen by a slot field just above the window offset. An address whose slot has no peripheral still runs the full access sequence and completes normally, but raises no select. The response is always OKAY. The peripheral address and direction hold between accesses, and the peripheral write data is always driven.

Top module: `periph_bridge`

## Requirements
- R1: While reset is low and after it is released, per_sel and per_enable are 0, sys_ready_out is 1, and per_addr, per_write, per_wdata and sys_rdata are all 0.
- R2: A transfer is accepted at a rising edge only if sys_ready_out, sys_sel and sys_ready_in are all high and sys_trans is 2'b10 (non-sequential) or 2'b11 (sequential). IDLE (2'b00) and BUSY (2'b01) transfers, or transfers with sys_sel or sys_ready_in low, leave ready high and start no access.
- R3: per_addr and per_write take sys_addr and sys_write at the accepting edge. They then hold those values until the next accepted transfer.
- R4: per_enable is low in the first cycle after the accepting edge, high in the second cycle, and low again after the third edge.
- R5: The slot is sys_addr[WIN_BITS +: SLOT_BITS]. If slot < NUM_PERIPH, per_sel bit slot is high in both access cycles and every other bit is low. A slot >= NUM_PERIPH raises no select. Outside an access, per_sel is all zero.
- R6: sys_ready_out is low in both access cycles and high at all other times.
- R7: On a write, per_wdata takes sys_wdata at the second edge of the access, which is the data-phase sample. Reads and non-accepted cycles leave per_wdata unchanged.
- R8: On a read, per_rdata is sampled at the third edge and shown on sys_rdata from then on, until the next read completes. Writes leave sys_rdata unchanged.
- R9: sys_resp is always 2'b00 (OKAY).
- R10: A new transfer presented in the cycle where ready returns high is accepted at that cycle's closing edge, so back-to-back accesses repeat every three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Bus clock |
| sys_rst_n | input | 1 | Active-low reset |
| sys_addr | input | ADDR_W | System address |
| sys_trans | input | 2 | Transfer type |
| sys_write | input | 1 | 1 = write, 0 = read |
| sys_wdata | input | DATA_W | System write data |
| sys_sel | input | 1 | Bridge slave select |
| sys_ready_in | input | 1 | Bus-wide ready |
| sys_ready_out | output | 1 | Bridge ready, low stretches transfer |
| sys_rdata | output | DATA_W | Read data to master |
| sys_resp | output | 2 | Transfer response, always OKAY |
| per_addr | output | ADDR_W | Peripheral address |
| per_write | output | 1 | Peripheral direction |
| per_wdata | output | DATA_W | Peripheral write data |
| per_enable | output | 1 | Peripheral enable phase |
| per_sel | output | NUM_PERIPH | One select per peripheral |
| per_rdata | input | DATA_W | Peripheral read data |

## Verification
Call the accepting edge edge zero. Address, direction and select must appear one cycle after it, and enable and the captured write data two cycles after it. Three cycles after it, ready is high again, the select and enable are low, and read data is on the bus. The bench drives every input on the falling edge. It steps through each access one falling edge per cycle and compares all outputs against its own model at each step. Non-accepted patterns are checked one cycle later, with the held address and data proving that nothing moved. Stimulus that must not be captured is randomised in the cycles just before and after each sampling edge.

// File: rtl/bridge_pkg.sv
`timescale 1ns/1ps
package bridge_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'b00,
      PH_SETUP  = 2'b01,
      PH_ENABLE = 2'b10
   } phase_t;

   localparam logic [1:0] TR_IDLE   = 2'b00;
   localparam logic [1:0] TR_BUSY   = 2'b01;
   localparam logic [1:0] TR_NONSEQ = 2'b10;
   localparam logic [1:0] TR_SEQ    = 2'b11;

   localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/bridge_decode.sv
`timescale 1ns/1ps
module bridge_decode #(
   parameter int NUM_PERIPH = 6,
   parameter int SLOT_BITS  = 3
) (
   input  logic [SLOT_BITS-1:0]  slot,
   output logic [NUM_PERIPH-1:0] hot
);
   // one comparator per populated window; unpopulated slots match nothing
   for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_win
      assign hot[i] = (slot == SLOT_BITS'(i));
   end
endmodule

// File: rtl/bridge_seq.sv
`timescale 1ns/1ps
module bridge_seq
   import bridge_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   accept,
   output phase_t phase
);
   phase_t phase_nx;

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_IDLE:   if (accept) phase_nx = PH_SETUP;
         PH_SETUP:  phase_nx = PH_ENABLE;
         PH_ENABLE: phase_nx = PH_IDLE;
         default:   phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= phase_nx;
   end
endmodule

// File: rtl/bridge_regs.sv
`timescale 1ns/1ps
module bridge_regs
   import bridge_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int NUM_PERIPH = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  accept,
   input  phase_t                phase,
   input  logic [ADDR_W-1:0]     in_addr,
   input  logic                  in_write,
   input  logic [DATA_W-1:0]     in_wdata,
   input  logic [NUM_PERIPH-1:0] in_hot,
   input  logic [DATA_W-1:0]     in_prdata,
   output logic [ADDR_W-1:0]     q_addr,
   output logic                  q_write,
   output logic [DATA_W-1:0]     q_wdata,
   output logic [NUM_PERIPH-1:0] q_hot,
   output logic [DATA_W-1:0]     q_rdata
);
   // address-phase capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_addr  <= '0;
         q_write <= 1'b0;
         q_hot   <= '0;
      end else if (accept) begin
         q_addr  <= in_addr;
         q_write <= in_write;
         q_hot   <= in_hot;
      end
   end

   // data-phase capture of write data, before the enable cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q_wdata <= '0;
      else if (phase == PH_SETUP && q_write) q_wdata <= in_wdata;
   end

   // read data taken on the last edge of a read access
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            q_rdata <= '0;
      else if (phase == PH_ENABLE && !q_write) q_rdata <= in_prdata;
   end
endmodule

// File: rtl/periph_bridge.sv
`timescale 1ns/1ps
module periph_bridge
   import bridge_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int NUM_PERIPH = 6,
   parameter int SLOT_BITS  = 3,
   parameter int WIN_BITS   = 12
) (
   input  logic                  sys_clk,
   input  logic                  sys_rst_n,
   input  logic [ADDR_W-1:0]     sys_addr,
   input  logic [1:0]            sys_trans,
   input  logic                  sys_write,
   input  logic [DATA_W-1:0]     sys_wdata,
   input  logic                  sys_sel,
   input  logic                  sys_ready_in,
   output logic                  sys_ready_out,
   output logic [DATA_W-1:0]     sys_rdata,
   output logic [1:0]            sys_resp,
   output logic [ADDR_W-1:0]     per_addr,
   output logic                  per_write,
   output logic [DATA_W-1:0]     per_wdata,
   output logic                  per_enable,
   output logic [NUM_PERIPH-1:0] per_sel,
   input  logic [DATA_W-1:0]     per_rdata
);
   localparam int SLOT_LSB = WIN_BITS;
   localparam int SLOT_CAP = 1 << SLOT_BITS;

   if (NUM_PERIPH < 1 || NUM_PERIPH > SLOT_CAP) begin : g_bad_count
      $error("NUM_PERIPH must lie in 1..2**SLOT_BITS");
   end
   if (SLOT_BITS < 1 || SLOT_LSB + SLOT_BITS > ADDR_W) begin : g_bad_slot
      $error("slot field must fit inside the address");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be at least 8");
   end

   phase_t                phase;
   logic                  accept;
   logic                  trans_live;
   logic [NUM_PERIPH-1:0] dec_hot;
   logic [NUM_PERIPH-1:0] hot_q;

   assign trans_live = (sys_trans == TR_NONSEQ) || (sys_trans == TR_SEQ);
   assign accept     = (phase == PH_IDLE) && sys_sel && trans_live && sys_ready_in;

   bridge_decode #(
      .NUM_PERIPH (NUM_PERIPH),
      .SLOT_BITS  (SLOT_BITS)
   ) u_dec (
      .slot (sys_addr[SLOT_LSB +: SLOT_BITS]),
      .hot  (dec_hot)
   );

   bridge_seq u_seq (
      .clk    (sys_clk),
      .rst_n  (sys_rst_n),
      .accept (accept),
      .phase  (phase)
   );

   bridge_regs #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .NUM_PERIPH (NUM_PERIPH)
   ) u_regs (
      .clk       (sys_clk),
      .rst_n     (sys_rst_n),
      .accept    (accept),
      .phase     (phase),
      .in_addr   (sys_addr),
      .in_write  (sys_write),
      .in_wdata  (sys_wdata),
      .in_hot    (dec_hot),
      .in_prdata (per_rdata),
      .q_addr    (per_addr),
      .q_write   (per_write),
      .q_wdata   (per_wdata),
      .q_hot     (hot_q),
      .q_rdata   (sys_rdata)
   );

   assign per_sel       = (phase != PH_IDLE) ? hot_q : '0;
   assign per_enable    = (phase == PH_ENABLE);
   assign sys_ready_out = (phase == PH_IDLE);
   assign sys_resp      = RESP_OKAY;
endmodule

// File: rtl/periph_bridge_chk.sv
`timescale 1ns/1ps
module periph_bridge_chk #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int NUM_PERIPH = 6,
   parameter int SLOT_BITS  = 3,
   parameter int WIN_BITS   = 12
) (
   input logic                  sys_clk,
   input logic                  sys_rst_n,
   input logic [ADDR_W-1:0]     sys_addr,
   input logic [1:0]            sys_trans,
   input logic                  sys_write,
   input logic [DATA_W-1:0]     sys_wdata,
   input logic                  sys_sel,
   input logic                  sys_ready_in,
   input logic                  sys_ready_out,
   input logic [DATA_W-1:0]     sys_rdata,
   input logic [1:0]            sys_resp,
   input logic [ADDR_W-1:0]     per_addr,
   input logic                  per_write,
   input logic [DATA_W-1:0]     per_wdata,
   input logic                  per_enable,
   input logic [NUM_PERIPH-1:0] per_sel,
   input logic [DATA_W-1:0]     per_rdata
);
   logic take;
   assign take = sys_ready_out && sys_sel && sys_trans[1] && sys_ready_in;

   a_r2_accept_stalls: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      take |=> !sys_ready_out);

   a_r2_ignored_keeps_ready: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      (sys_ready_out && !take) |=> (sys_ready_out && per_sel == '0));

   a_r3_addr_held_in_enable: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      per_enable |-> ($stable(per_addr) && $stable(per_write)));

   a_r4_enable_single_cycle: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      per_enable |=> !per_enable);

   a_r4_setup_then_enable: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      (!sys_ready_out && !per_enable) |=> per_enable);

   a_r5_sel_onehot: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      $onehot0(per_sel));

   a_r5_sel_stable_in_enable: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      per_enable |-> $stable(per_sel));

   a_r6_ready_low_in_enable: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      per_enable |-> !sys_ready_out);

   a_r7_read_keeps_wdata: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      (!sys_ready_out && !per_enable && !per_write) |=> $stable(per_wdata));

   a_r8_rdata_held_while_ready: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      $past(sys_ready_out) |-> $stable(sys_rdata));
endmodule

bind periph_bridge periph_bridge_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .NUM_PERIPH (NUM_PERIPH),
   .SLOT_BITS  (SLOT_BITS),
   .WIN_BITS   (WIN_BITS)
) u_chk (.*);

// File: tb/periph_bridge_test.sv
`timescale 1ns/1ps
module periph_bridge_test;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int NP = 6;
   localparam int SB = 3;
   localparam int WB = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] sys_addr = '0;
   logic [1:0]    sys_trans = 2'b00;
   logic          sys_write = 1'b0;
   logic [DW-1:0] sys_wdata = '0;
   logic          sys_sel = 1'b0;
   logic          sys_ready_in = 1'b1;
   logic          sys_ready_out;
   logic [DW-1:0] sys_rdata;
   logic [1:0]    sys_resp;
   logic [AW-1:0] per_addr;
   logic          per_write;
   logic [DW-1:0] per_wdata;
   logic          per_enable;
   logic [NP-1:0] per_sel;
   logic [DW-1:0] per_rdata = '0;

   int checks = 0;
   int errors = 0;

   logic [AW-1:0] exp_addr = '0;
   logic          exp_write = 1'b0;
   logic [DW-1:0] exp_wdata = '0;
   logic [DW-1:0] exp_rdata = '0;

   always #2.5 clk = ~clk;

   periph_bridge #(
      .ADDR_W (AW), .DATA_W (DW), .NUM_PERIPH (NP), .SLOT_BITS (SB), .WIN_BITS (WB)
   ) uut (
      .sys_clk (clk), .sys_rst_n (rst_n), .sys_addr (sys_addr), .sys_trans (sys_trans),
      .sys_write (sys_write), .sys_wdata (sys_wdata), .sys_sel (sys_sel),
      .sys_ready_in (sys_ready_in), .sys_ready_out (sys_ready_out), .sys_rdata (sys_rdata),
      .sys_resp (sys_resp), .per_addr (per_addr), .per_write (per_write),
      .per_wdata (per_wdata), .per_enable (per_enable), .per_sel (per_sel),
      .per_rdata (per_rdata)
   );

   function automatic logic [NP-1:0] sel_of(input logic [AW-1:0] a);
      int slot = int'(a[WB +: SB]);
      return (slot < NP) ? NP'(1) << slot : '0;
   endfunction

   function automatic logic [AW-1:0] addr_for(input int slot, input logic [AW-1:0] rnd);
      logic [AW-1:0] a = rnd;
      a[WB +: SB] = SB'(slot);
      return a;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic drive_idle();
      sys_sel = 1'b0; sys_trans = 2'b00; sys_ready_in = 1'b1;
      sys_addr = $urandom; sys_write = 1'($urandom);
   endtask

   // one full access; called on a falling edge, returns on the falling edge after ready rises
   task automatic xfer(input logic [AW-1:0] a, input logic wr, input logic [DW-1:0] wd,
                       input logic [DW-1:0] rd, input logic [1:0] tr);
      sys_sel = 1'b1; sys_trans = tr; sys_addr = a; sys_write = wr; sys_ready_in = 1'b1;
      sys_wdata = $urandom; per_rdata = $urandom;
      @(posedge clk); @(negedge clk);
      exp_addr = a; exp_write = wr;
      drive_idle(); sys_wdata = wd;
      chk("R6 ready low in setup", 64'(sys_ready_out), 64'(0));
      chk("R4 enable low in setup", 64'(per_enable), 64'(0));
      chk("R5 select in setup", 64'(per_sel), 64'(sel_of(a)));
      chk("R3 address in setup", 64'(per_addr), 64'(exp_addr));
      chk("R3 direction in setup", 64'(per_write), 64'(exp_write));
      chk("R7 wdata before capture", 64'(per_wdata), 64'(exp_wdata));
      @(posedge clk); @(negedge clk);
      if (wr) exp_wdata = wd;
      sys_wdata = $urandom; per_rdata = rd;
      chk("R4 enable high", 64'(per_enable), 64'(1));
      chk("R6 ready low in enable", 64'(sys_ready_out), 64'(0));
      chk("R5 select in enable", 64'(per_sel), 64'(sel_of(a)));
      chk("R7 wdata in enable", 64'(per_wdata), 64'(exp_wdata));
      @(posedge clk); @(negedge clk);
      if (!wr) exp_rdata = rd;
      per_rdata = $urandom;
      chk("R4 enable low after access", 64'(per_enable), 64'(0));
      chk("R5 select low after access", 64'(per_sel), 64'(0));
      chk("R6 ready back high", 64'(sys_ready_out), 64'(1));
      chk("R8 read data returned", 64'(sys_rdata), 64'(exp_rdata));
      chk("R7 wdata held", 64'(per_wdata), 64'(exp_wdata));
      chk("R9 response okay", 64'(sys_resp), 64'(0));
      chk("R3 address held", 64'(per_addr), 64'(exp_addr));
   endtask

   // a pattern that must not start an access
   task automatic no_take(input logic sel, input logic [1:0] tr, input logic rdy);
      sys_sel = sel; sys_trans = tr; sys_ready_in = rdy;
      sys_addr = $urandom; sys_write = 1'($urandom); sys_wdata = $urandom; per_rdata = $urandom;
      @(posedge clk); @(negedge clk);
      drive_idle();
      chk("R2 ignored keeps ready", 64'(sys_ready_out), 64'(1));
      chk("R2 ignored raises no select", 64'(per_sel), 64'(0));
      chk("R2 ignored keeps address", 64'(per_addr), 64'(exp_addr));
      chk("R2 ignored keeps direction", 64'(per_write), 64'(exp_write));
      chk("R7 ignored keeps wdata", 64'(per_wdata), 64'(exp_wdata));
      chk("R8 ignored keeps rdata", 64'(sys_rdata), 64'(exp_rdata));
      chk("R9 response okay idle", 64'(sys_resp), 64'(0));
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #750000;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk("R1 ready in reset", 64'(sys_ready_out), 64'(1));
      chk("R1 select in reset", 64'(per_sel), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 enable after reset", 64'(per_enable), 64'(0));
      chk("R1 address after reset", 64'(per_addr), 64'(0));
      chk("R1 direction after reset", 64'(per_write), 64'(0));
      chk("R1 wdata after reset", 64'(per_wdata), 64'(0));
      chk("R1 rdata after reset", 64'(sys_rdata), 64'(0));
      chk("R1 ready after reset", 64'(sys_ready_out), 64'(1));

      // directed corners
      xfer(addr_for(0, 32'h1234_5678), 1'b1, 32'hCAFE_0001, 32'h0, 2'b10);
      xfer(addr_for(NP-1, 32'h0BAD_F00D), 1'b0, 32'h0, 32'hA5A5_5A5A, 2'b11);  // R10 back to back, SEQ
      xfer(addr_for(7, 32'h7777_0000), 1'b1, 32'hDEAD_BEEF, 32'h0, 2'b10);     // R5 unmatched slot
      xfer(addr_for(6, 32'h4444_0004), 1'b0, 32'h0, 32'h1111_2222, 2'b10);     // R5 unmatched read
      no_take(1'b1, 2'b00, 1'b1);   // R2 IDLE
      no_take(1'b1, 2'b01, 1'b1);   // R2 BUSY
      no_take(1'b0, 2'b10, 1'b1);   // R2 not selected
      no_take(1'b1, 2'b11, 1'b0);   // R2 ready_in low
      xfer(addr_for(2, 32'h2000_2000), 1'b0, 32'h0, 32'h3333_4444, 2'b10);

      // constrained random mix
      for (int i = 0; i < 300; i++) begin
         int op = int'($urandom % 5);
         if (op == 0) begin
            logic [1:0] tr = 2'($urandom);
            logic sel = 1'($urandom);
            logic rdy = 1'($urandom);
            if (sel && rdy && tr[1]) tr[1] = 1'b0;
            no_take(sel, tr, rdy);
         end else begin
            xfer(addr_for(int'($urandom % 8), $urandom), 1'($urandom), $urandom, $urandom,
                 {1'b1, 1'($urandom)});
         end
      end

      summary();
      $finish;
   end
endmodule